// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into a register of pending requests. A software-visible mode byte picks, line by line, how each request is formed. A line in level mode requests for exactly as long as it is held high. A line in edge mode latches a request on a low-to-high transition, and the request then stays pending until the consumer acknowledges it.

The mode byte is written and read through a simple byte port. A hard-wired parameter mask fixes chosen mode bits at zero, so those lines are always edge triggered. This lets one design serve instances whose lines have different wiring constraints. Prioritisation, masking, in-service tracking and address decoding belong to the surrounding logic. The block only keeps the request vector and the last sampled level of each line.

Top module: `irq_req_latch`

## Requirements
- R1: Reset clears the request vector, the mode byte and the stored last level of every line, so a line that is high in the first clock after reset counts as a rising edge.
- R2: A line whose mode bit is 1 (level) shows on its request bit the value the line had at the previous clock edge; an acknowledge of that line has no effect.
- R3: A line whose mode bit is 0 (edge) sets its request bit only when it is high at a clock edge and was low at the clock edge before; holding it high does not set it again.
- R4: In edge mode a line going low leaves a pending request bit set.
- R5: An acknowledge bit clears the matching edge-mode request at the next clock edge, unless a rising edge on that line arrives at the same edge, in which case the request stays set.
- R6: A write stores the write data ANDed with the parameter MODE_MASK, and the read port shows the stored byte from the clock after the write; without a write the byte does not change.
- R7: Mode bits whose MODE_MASK bit is 0 always read 0 and their lines always behave as edge triggered, whatever is written (default mask 0xF8: lines 0 to 2 fixed to edge).
- R8: A new mode byte governs request formation from the clock edge after the one that stores it; the edge that stores it still uses the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 8 | Raw interrupt line levels |
| ackIn | input | 8 | Per-line acknowledge strobes |
| modeWrEn | input | 1 | Write strobe for the mode byte |
| modeWrData | input | 8 | Mode byte write data (1 = level, 0 = edge) |
| modeRdData | output | 8 | Current masked mode byte |
| reqOut | output | 8 | Pending request vector |

## Verification
Every result of this block is due one clock edge after its stimulus. A request bit reflects the lines and acknowledges applied before that edge, and a written mode byte is readable after that edge. A new mode byte shapes requests only from the following edge onward. The bench drives all inputs on the falling edge and lets exactly one rising edge pass. It then compares both outputs on the next falling edge against a model that it advances once for that edge. The model is updated with the mode byte held before the edge, which keeps the one-edge lag of R8 in step with the design.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned IRL_LINES = 8;

  typedef logic [IRL_LINES-1:0] lineVec_t;

  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic     modeLoad;
    lineVec_t modeNext;
    lineVec_t setLines;
    lineVec_t clrLines;
  } reqStrobe_t;
endpackage

// File: rtl/irl_ctrl.sv
module irl_ctrl
  import irl_pkg::*;
#(
  parameter lineVec_t MODE_MASK = lineVec_t'(8'hF8)
) (
  input  lineVec_t   lineIn,
  input  lineVec_t   ackIn,
  input  lineVec_t   modeCur,
  input  lineVec_t   lastLevel,
  input  logic       modeWrEn,
  input  lineVec_t   modeWrData,
  output reqStrobe_t strobe
);
  lineVec_t riseVec;
  lineVec_t setVec;
  lineVec_t clrVec;
  lineVec_t nextMode;

  assign riseVec = lineIn & ~lastLevel;

  for (genvar i = 0; i < IRL_LINES; i++) begin : g_line
    if (MODE_MASK[i]) begin : g_sel
      // Writable mode bit: the line follows the selected trigger style.
      assign nextMode[i] = modeWrData[i];
      always_comb begin
        if (modeCur[i]) begin
          setVec[i] = lineIn[i];
          clrVec[i] = ~lineIn[i];
        end else begin
          setVec[i] = riseVec[i];
          clrVec[i] = ackIn[i] & ~riseVec[i];
        end
      end
    end else begin : g_edge
      // Mode bit tied low: the line is always edge triggered.
      assign nextMode[i] = 1'b0;
      assign setVec[i]   = riseVec[i];
      assign clrVec[i]   = ackIn[i] & ~riseVec[i];
    end
  end

  always_comb begin
    strobe.modeLoad = modeWrEn;
    strobe.modeNext = nextMode;
    strobe.setLines = setVec;
    strobe.clrLines = clrVec;
  end
endmodule

// File: rtl/irl_datapath.sv
module irl_datapath
  import irl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineVec_t   lineIn,
  input  reqStrobe_t strobe,
  output lineVec_t   modeCur,
  output lineVec_t   lastLevel,
  output lineVec_t   reqVec
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCur   <= '0;
      lastLevel <= '0;
      reqVec    <= '0;
    end else begin
      lastLevel <= lineIn;
      reqVec    <= (reqVec & ~strobe.clrLines) | strobe.setLines;
      if (strobe.modeLoad) modeCur <= strobe.modeNext;
    end
  end

  // R1: the first edge after reset sees an all-low history.
  a_r1_history_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lastLevel == $past(lineIn));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irl_pkg::*;
#(
  parameter logic [IRL_LINES-1:0] MODE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRL_LINES-1:0] lineIn,
  input  logic [IRL_LINES-1:0] ackIn,
  input  logic                 modeWrEn,
  input  logic [IRL_LINES-1:0] modeWrData,
  output logic [IRL_LINES-1:0] modeRdData,
  output logic [IRL_LINES-1:0] reqOut
);
  reqStrobe_t strobe;
  lineVec_t   modeCur;
  lineVec_t   lastLevel;

  irl_ctrl #(.MODE_MASK(MODE_MASK)) u_ctrl (
    .lineIn    (lineIn),
    .ackIn     (ackIn),
    .modeCur   (modeCur),
    .lastLevel (lastLevel),
    .modeWrEn  (modeWrEn),
    .modeWrData(modeWrData),
    .strobe    (strobe)
  );

  irl_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .strobe   (strobe),
    .modeCur  (modeCur),
    .lastLevel(lastLevel),
    .reqVec   (reqOut)
  );

  assign modeRdData = modeCur;

  a_r2_level_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqOut ^ $past(lineIn)) & $past(modeRdData)) == '0);

  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(~modeRdData & lineIn & ~lastLevel) & ~reqOut) == '0);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(~modeRdData & ~reqOut & ~(lineIn & ~lastLevel)) & reqOut) == '0);

  a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(~modeRdData & reqOut & ~ackIn) & ~reqOut) == '0);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(~modeRdData & ackIn & ~(lineIn & ~lastLevel)) & reqOut) == '0);

  a_r6_write_masked: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> modeRdData == ($past(modeWrData) & MODE_MASK));

  a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrEn |=> $stable(modeRdData));

  a_r7_fixed_edge: assert property (@(posedge clk) disable iff (!rstN)
    (modeRdData & ~MODE_MASK) == '0);
endmodule

// File: tb/sim_irq_req_latch.sv
module sim_irq_req_latch;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lineIn = '0;
  logic [7:0] ackIn = '0;
  logic       modeWrEn = 1'b0;
  logic [7:0] modeWrData = '0;
  logic [7:0] modeRdData;
  logic [7:0] reqOut;

  int nChecks = 0;
  int nFails = 0;

  logic [7:0] expReq = '0;
  logic [7:0] expMode = '0;
  logic [7:0] expLast = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  irq_req_latch #(.MODE_MASK(MASK)) u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .ackIn(ackIn),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modeRdData(modeRdData), .reqOut(reqOut)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Apply one set of inputs, let one rising edge pass, compare both outputs.
  task automatic step(input string tag, input logic [7:0] ln,
                      input logic [7:0] ak, input logic wr,
                      input logic [7:0] wd);
    logic [7:0] rise;
    lineIn = ln; ackIn = ak; modeWrEn = wr; modeWrData = wd;
    @(posedge clk);
    rise = ln & ~expLast;
    for (int i = 0; i < 8; i++) begin
      if (expMode[i]) expReq[i] = ln[i];
      else            expReq[i] = rise[i] | (expReq[i] & ~ak[i]);
    end
    expLast = ln;
    if (wr) expMode = wd & MASK;
    @(negedge clk);
    check(tag, "reqOut", reqOut, expReq);
    check(tag, "modeRdData", modeRdData, expMode);
  endtask

  initial begin
    #(150000 * 10);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held with lines high.
    lineIn = 8'hFF;
    @(negedge clk);
    check("R1", "reqOut", reqOut, 8'h00);
    check("R1", "modeRdData", modeRdData, 8'h00);
    rstN = 1'b1;
    // R1: lines high at release count as rising edges (all edge mode).
    step("R1", 8'h05, 8'h00, 1'b0, 8'h00);
    step("R5", 8'h00, 8'h05, 1'b0, 8'h00);
    step("R3", 8'h01, 8'h00, 1'b0, 8'h00);
    step("R3", 8'h01, 8'h00, 1'b0, 8'h00);   // held high: no retrigger
    step("R4", 8'h00, 8'h00, 1'b0, 8'h00);   // low does not clear
    step("R5", 8'h00, 8'h01, 1'b0, 8'h00);   // ack clears
    step("R5", 8'h01, 8'h01, 1'b0, 8'h00);   // ack with rising edge: stays
    step("R3", 8'h00, 8'h00, 1'b0, 8'h00);
    // R8: write level mode with a rising edge on line 4 in the same cycle.
    step("R8", 8'h10, 8'h00, 1'b1, 8'hFF);
    check("R7", "mode fixed bits", modeRdData & ~MASK, 8'h00);
    step("R2", 8'hF1, 8'hF0, 1'b0, 8'h00);   // ack on level lines ignored
    step("R2", 8'h01, 8'h00, 1'b0, 8'h00);   // level lines drop
    step("R7", 8'h06, 8'h00, 1'b0, 8'h00);   // lines 1,2 still edge
    step("R7", 8'h00, 8'h00, 1'b0, 8'h00);
    // R6/R7: every possible mode byte.
    for (int v = 0; v < 256; v++) begin
      step("R6", 8'h00, 8'hFF, 1'b1, 8'(v));
      step("R6", 8'h00, 8'h00, 1'b0, 8'h00);
    end
    // R2/R3/R4/R5/R8: pseudo-random sweep with occasional mode writes.
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ln, ak;
      logic wr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ln = lfsr[7:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ak = lfsr[7:0] & lfsr[15:8];
      wr = (lfsr[3:0] == 4'h0);
      step("R2/R3/R4/R5/R8", ln, ak, wr, lfsr[15:8]);
    end
    // R1: reset mid-run clears everything.
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "reqOut", reqOut, 8'h00);
    check("R1", "modeRdData", modeRdData, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule